// File: doc/BRIEF.md
# Three-Dimensional Element Index Remapper

This block sits beside an element loop that walks a vector operation one element at a time. It turns the loop position into a reordered element offset for up to three operand registers at the same time. Each offset follows a shape descriptor. The descriptor gives the sizes of three dimensions, each stored as the real size minus one, and a code that picks the order in which the nested loops over those dimensions run.

Three shape words describe up to three shapes. A binding word ties up to three register numbers to those shapes. Every operand register number is matched against the bindings. A matched operand receives the offset from its shape. An unmatched operand, or one bound to a disabled or illegal shape, receives the plain linear element position. If the shape's volume is smaller than the number of elements walked, the sequence repeats.

The loop is driven by a step pulse. A restart input moves the walk to any saved element position so that an interrupted loop can resume. Seeking that position takes one cycle per skipped element, and the valid flag stays low until the seek is done.

Top module: `shape_remap`

## Requirements
- R1: After reset the valid output is 1, every offset is 0 and the error flag is 0.
- R2: A shape word holds the x, y and z sizes minus one in bits 6..0, 14..8 and 22..16, and the order code in bits 26..24. The offset for counters (x, y, z) is x + y·X + z·X·Y, where X and Y are the real x and y sizes.
- R3: Order codes 0 to 5 give the dimension sequences (x,y,z), (x,z,y), (y,x,z), (y,z,x), (z,x,y) and (z,y,x). The first dimension of the sequence advances on every element. When a dimension passes its last value it returns to 0 and the next dimension in the sequence advances.
- R4: Once X·Y·Z elements have been walked, all three counters return to 0 and the offset sequence repeats.
- R5: An operand bound to a shape word that is entirely zero receives the linear element position.
- R6: An operand bound to a shape whose order code is 6 or 7 receives the linear element position, and the error flag is 1 in the same cycle as that offset. The flag is 0 when no operand resolves to such a shape.
- R7: The binding word holds register numbers in bits 6..0, 14..8 and 22..16, with shape selectors for them in bits 25..24, 27..26 and 29..28 respectively. A selector of 3 makes that binding inactive. When several active bindings match an operand, the binding in the lowest bit positions wins.
- R8: An operand whose register number matches no active binding receives the linear element position.
- R9: A restart with start position s drops valid in the next cycle when s is nonzero. Valid rises exactly s cycles after the restart edge, and the offsets then belong to element s. With s = 0, valid is 1 after the restart edge and all offsets are 0.
- R10: A step while valid is high moves every offset to the next element at the next edge. Without a step, and with the configuration held steady, the offsets hold. A step while valid is low has no effect.
- R11: Restart takes priority over a step asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shape_cfg | input | 96 | Three shape words, shape k in bits 32k+31..32k |
| remap_cfg | input | 32 | Binding word tying register numbers to shapes |
| op_regs | input | 21 | Three 7-bit operand register numbers, operand j in bits 7j+6..7j |
| restart | input | 1 | Reload the walk and seek to start_idx |
| start_idx | input | 7 | Element position to resume at |
| step | input | 1 | Advance to the next element |
| elem_off | output | 63 | Three 21-bit remapped offsets, operand j in bits 21j+20..21j |
| off_valid | output | 1 | Offsets belong to the current element |
| perm_err | output | 1 | An operand resolved to a shape with an illegal order code |

## Verification
A counter that carries into the wrong dimension, or that wraps at the wrong limit, shows up in the next registered offset. That is the first element where the expected carry happens, so the bench steps through several full volumes for every order code and compares each element. A seek counter that is off by one shows up as valid rising one cycle early or late, or as an offset for the neighbouring element. Stale binding or shape selection shows up as a linear offset where a remapped one is expected, or the reverse, in the cycle right after the configuration changes.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int DIM_W        = 7;
  localparam int RIDX_W       = 7;
  localparam int CFG_W        = 32;
  localparam int NUM_SHAPES   = 3;
  localparam int NUM_DIMS     = 3;
  localparam int NUM_BINDS    = 3;
  localparam int FIELD_STRIDE = 8;
  localparam int PERM_LSB     = 24;
  localparam int PERM_W       = 3;
  localparam int SEL_LSB      = 24;
  localparam int SEL_W        = 2;

  localparam logic [SEL_W-1:0] SEL_OFF = 2'b11;

  typedef logic [DIM_W-1:0]      dim_t;
  // Slot k (bits 2k+1..2k) names the dimension that advances k-th.
  typedef logic [2*NUM_DIMS-1:0] order_t;

  function automatic order_t perm_order(input logic [PERM_W-1:0] code);
    case (code)
      3'd1:    return {2'd1, 2'd2, 2'd0};
      3'd2:    return {2'd2, 2'd0, 2'd1};
      3'd3:    return {2'd0, 2'd2, 2'd1};
      3'd4:    return {2'd1, 2'd0, 2'd2};
      3'd5:    return {2'd0, 2'd1, 2'd2};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic logic perm_illegal(input logic [PERM_W-1:0] code);
    return code > 3'd5;
  endfunction

endpackage

// File: rtl/shape_walker.sv
module shape_walker
  import remap_pkg::*;
#(
  parameter int OFF_W = 3*DIM_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             load,
  input  logic             adv,
  output logic [OFF_W-1:0] nxt_off,
  output logic             active,
  output logic             bad_perm
);

  localparam int LIM_W = DIM_W + 1;

  logic [LIM_W-1:0] lim [NUM_DIMS];
  dim_t             cnt_q [NUM_DIMS];
  dim_t             cnt_d [NUM_DIMS];
  order_t           ord;
  logic             carry;
  logic             go;
  logic [OFF_W-1:0] span_x;
  logic [OFF_W-1:0] span_xy;

  for (genvar gd = 0; gd < NUM_DIMS; gd++) begin : g_lim
    assign lim[gd] = LIM_W'(cfg[gd*FIELD_STRIDE +: DIM_W]) + LIM_W'(1);
  end

  assign ord      = perm_order(cfg[PERM_LSB +: PERM_W]);
  assign bad_perm = perm_illegal(cfg[PERM_LSB +: PERM_W]);
  assign active   = (cfg != '0) && !bad_perm;

  // Odometer step: walk the order slots, carrying while a dimension wraps.
  always_comb begin
    carry = 1'b1;
    go    = 1'b0;
    for (int d = 0; d < NUM_DIMS; d++) cnt_d[d] = cnt_q[d];
    if (load) begin
      for (int d = 0; d < NUM_DIMS; d++) cnt_d[d] = '0;
    end else if (adv) begin
      for (int k = 0; k < NUM_DIMS; k++) begin
        go = carry;
        for (int d = 0; d < NUM_DIMS; d++) begin
          if (go && (ord[2*k +: 2] == 2'(d))) begin
            if (LIM_W'(cnt_q[d]) + LIM_W'(1) >= lim[d]) begin
              cnt_d[d] = '0;
            end else begin
              cnt_d[d] = cnt_q[d] + DIM_W'(1);
              carry    = 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    span_x  = OFF_W'(lim[0]);
    span_xy = OFF_W'(lim[0]) * OFF_W'(lim[1]);
    nxt_off = OFF_W'(cnt_d[0])
            + OFF_W'(cnt_d[1]) * span_x
            + OFF_W'(cnt_d[2]) * span_xy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NUM_DIMS; d++) cnt_q[d] <= '0;
    end else begin
      for (int d = 0; d < NUM_DIMS; d++) cnt_q[d] <= cnt_d[d];
    end
  end

endmodule

// File: rtl/op_binder.sv
module op_binder
  import remap_pkg::*;
(
  input  logic [CFG_W-1:0]  remap_cfg,
  input  logic [RIDX_W-1:0] op_reg,
  output logic              hit,
  output logic [SEL_W-1:0]  shape_sel
);

  // Scan from the highest binding down so the lowest matching one wins.
  always_comb begin
    hit       = 1'b0;
    shape_sel = '0;
    for (int k = NUM_BINDS-1; k >= 0; k--) begin
      if ((remap_cfg[k*FIELD_STRIDE +: RIDX_W] == op_reg) &&
          (remap_cfg[SEL_LSB + SEL_W*k +: SEL_W] != SEL_OFF)) begin
        hit       = 1'b1;
        shape_sel = remap_cfg[SEL_LSB + SEL_W*k +: SEL_W];
      end
    end
  end

endmodule

// File: rtl/shape_remap.sv
module shape_remap
  import remap_pkg::*;
#(
  parameter int NUM_OPS = 3,
  parameter int START_W = 7,
  parameter int OFF_W   = 3*DIM_W
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SHAPES*CFG_W-1:0] shape_cfg,
  input  logic [CFG_W-1:0]            remap_cfg,
  input  logic [NUM_OPS*RIDX_W-1:0]   op_regs,
  input  logic                        restart,
  input  logic [START_W-1:0]          start_idx,
  input  logic                        step,
  output logic [NUM_OPS*OFF_W-1:0]    elem_off,
  output logic                        off_valid,
  output logic                        perm_err
);

  logic [START_W-1:0] seek_q;
  logic               valid_q;
  logic [OFF_W-1:0]   lin_q;
  logic [OFF_W-1:0]   lin_d;
  logic               adv;

  logic [OFF_W-1:0]   w_off [NUM_SHAPES];
  logic               w_act [NUM_SHAPES];
  logic               w_bad [NUM_SHAPES];

  logic               b_hit [NUM_OPS];
  logic [SEL_W-1:0]   b_sel [NUM_OPS];

  logic [OFF_W-1:0]   off_d [NUM_OPS];
  logic [OFF_W-1:0]   off_q [NUM_OPS];
  logic               err_d;
  logic               err_q;

  // Seeking advances unconditionally; a step only counts once valid.
  assign adv   = !restart && ((seek_q != '0) || (step && valid_q));
  assign lin_d = restart ? '0 : (adv ? lin_q + OFF_W'(1) : lin_q);

  for (genvar gs = 0; gs < NUM_SHAPES; gs++) begin : g_walk
    shape_walker #(.OFF_W(OFF_W)) u_walk (
      .clk      (clk),
      .rst      (rst),
      .cfg      (shape_cfg[gs*CFG_W +: CFG_W]),
      .load     (restart),
      .adv      (adv),
      .nxt_off  (w_off[gs]),
      .active   (w_act[gs]),
      .bad_perm (w_bad[gs])
    );
  end

  for (genvar go = 0; go < NUM_OPS; go++) begin : g_bind
    op_binder u_bind (
      .remap_cfg (remap_cfg),
      .op_reg    (op_regs[go*RIDX_W +: RIDX_W]),
      .hit       (b_hit[go]),
      .shape_sel (b_sel[go])
    );
  end

  always_comb begin
    err_d = 1'b0;
    for (int j = 0; j < NUM_OPS; j++) begin
      off_d[j] = lin_d;
      for (int s = 0; s < NUM_SHAPES; s++) begin
        if (b_hit[j] && (b_sel[j] == SEL_W'(s))) begin
          if (w_act[s]) off_d[j] = w_off[s];
          if (w_bad[s]) err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seek_q  <= '0;
      valid_q <= 1'b1;
      lin_q   <= '0;
      err_q   <= 1'b0;
      for (int j = 0; j < NUM_OPS; j++) off_q[j] <= '0;
    end else begin
      if (restart) begin
        seek_q  <= start_idx;
        valid_q <= (start_idx == '0);
      end else if (seek_q != '0) begin
        seek_q  <= seek_q - START_W'(1);
        valid_q <= (seek_q == START_W'(1));
      end
      lin_q <= lin_d;
      err_q <= err_d;
      for (int j = 0; j < NUM_OPS; j++) off_q[j] <= off_d[j];
    end
  end

  for (genvar gj = 0; gj < NUM_OPS; gj++) begin : g_out
    assign elem_off[gj*OFF_W +: OFF_W] = off_q[gj];
  end
  assign off_valid = valid_q;
  assign perm_err  = err_q;

endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
#(
  parameter int NUM_OPS = 3,
  parameter int START_W = 7,
  parameter int OFF_W   = 3*DIM_W
)(
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_SHAPES*CFG_W-1:0] shape_cfg,
  input logic [CFG_W-1:0]            remap_cfg,
  input logic [NUM_OPS*RIDX_W-1:0]   op_regs,
  input logic                        restart,
  input logic [START_W-1:0]          start_idx,
  input logic                        step,
  input logic [NUM_OPS*OFF_W-1:0]    elem_off,
  input logic                        off_valid,
  input logic                        perm_err
);

  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int s = 0; s < NUM_SHAPES; s++)
      if (perm_illegal(shape_cfg[s*CFG_W + PERM_LSB +: PERM_W])) any_bad = 1'b1;
  end

  // R9
  seek_low_chk: assert property (@(posedge clk) disable iff (rst)
    restart && (start_idx != '0) |=> !off_valid);

  // R9
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    restart && (start_idx == '0) |=> off_valid && (elem_off == '0));

  // R10
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    off_valid && !restart |=> off_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    off_valid && !restart && !step && $stable(shape_cfg) && $stable(remap_cfg)
      && $stable(op_regs) |=> $stable(elem_off));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !any_bad |=> !perm_err);

endmodule

bind shape_remap remap_chk #(
  .NUM_OPS (NUM_OPS),
  .START_W (START_W),
  .OFF_W   (OFF_W)
) u_remap_chk (.*);

// File: tb/tb_shape_remap.sv
module tb_shape_remap;

  localparam int NOPS = 3;
  localparam int OW   = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] shape_cfg = '0;
  logic [31:0] remap_cfg = '0;
  logic [20:0] op_regs = '0;
  logic        restart = 1'b0;
  logic [6:0]  start_idx = '0;
  logic        step = 1'b0;
  logic [62:0] elem_off;
  logic        off_valid;
  logic        perm_err;

  int n_chk = 0;
  int n_fail = 0;
  int cur_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shape_remap dut (
    .clk(clk), .rst(rst), .shape_cfg(shape_cfg), .remap_cfg(remap_cfg),
    .op_regs(op_regs), .restart(restart), .start_idx(start_idx), .step(step),
    .elem_off(elem_off), .off_valid(off_valid), .perm_err(perm_err)
  );

  function automatic logic [31:0] mk_shape(int x, int y, int z, int p);
    return {5'b0, 3'(p), 1'b0, 7'(z), 1'b0, 7'(y), 1'b0, 7'(x)};
  endfunction

  function automatic logic [31:0] mk_bind(int r0, int s0, int r1, int s1, int r2, int s2);
    return {2'b0, 2'(s2), 2'(s1), 2'(s0), 1'b0, 7'(r2), 1'b0, 7'(r1), 1'b0, 7'(r0)};
  endfunction

  // Expected offset for one operand at element n; e reports an illegal code.
  function automatic int model_off(logic [95:0] sh, logic [31:0] rm, int r, int n, output bit e);
    int sel = -1;
    int lim[3];
    int ord[3];
    int c[3];
    int p;
    logic [31:0] cfg;
    e = 1'b0;
    for (int k = 0; k < 3; k++)
      if (sel < 0 && int'(rm[k*8 +: 7]) == r && rm[24+2*k +: 2] != 2'b11)
        sel = int'(rm[24+2*k +: 2]);
    if (sel < 0) return n;
    cfg = sh[sel*32 +: 32];
    if (cfg == 32'd0) return n;
    if (cfg[26:24] > 3'd5) begin e = 1'b1; return n; end
    for (int d = 0; d < 3; d++) lim[d] = int'(cfg[d*8 +: 7]) + 1;
    case (cfg[26:24])
      3'd0: ord = '{0, 1, 2};
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    p = n % (lim[0] * lim[1] * lim[2]);
    for (int k = 0; k < 3; k++) begin
      c[ord[k]] = p % lim[ord[k]];
      p = p / lim[ord[k]];
    end
    return c[0] + c[1] * lim[0] + c[2] * lim[0] * lim[1];
  endfunction

  function automatic int got(int j);
    return int'(elem_off[j*OW +: OW]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_now(string req);
    bit e;
    bit any_e = 1'b0;
    int exp;
    chk(off_valid == 1'b1, req, int'(off_valid), 1);
    for (int j = 0; j < NOPS; j++) begin
      exp = model_off(shape_cfg, remap_cfg, int'(op_regs[j*7 +: 7]), cur_n, e);
      any_e |= e;
      chk(got(j) == exp, req, got(j), exp);
    end
    chk(perm_err == any_e, req, int'(perm_err), int'(any_e));
  endtask

  // Restart at s; optionally hold step high throughout (R10, R11).
  task automatic restart_to(int s, bit hold_step, string req);
    int k = 0;
    restart = 1'b1;
    start_idx = 7'(s);
    step = hold_step;
    tick();
    restart = 1'b0;
    if (s != 0) chk(off_valid == 1'b0, req, int'(off_valid), 0);
    while (!off_valid && k < 300) begin
      tick();
      k++;
    end
    step = 1'b0;
    chk(k == s, req, k, s);
    cur_n = s;
    check_now(req);
  endtask

  task automatic do_steps(int cnt, string req);
    for (int i = 0; i < cnt; i++) begin
      step = 1'b1;
      tick();
      step = 1'b0;
      cur_n++;
      check_now(req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(off_valid == 1'b1, "R1", int'(off_valid), 1);
    chk(elem_off == '0, "R1", int'(elem_off[20:0]), 0);
    chk(perm_err == 1'b0, "R1", int'(perm_err), 0);

    // R2 R3: 3x4x5 shape, order code 2 (y fastest), op 1 unbound (R8)
    shape_cfg = {32'd0, 32'd0, mk_shape(2, 3, 4, 2)};
    remap_cfg = mk_bind(5, 0, 40, 3, 41, 3);
    op_regs   = {7'd5, 7'd9, 7'd5};
    restart_to(0, 1'b0, "R9");
    do_steps(1, "R3");
    chk(got(0) == 3, "R3", got(0), 3);
    do_steps(3, "R3");
    chk(got(0) == 1, "R3", got(0), 1);
    chk(got(1) == 4, "R8", got(1), 4);
    do_steps(20, "R2");

    // R4: volume 4 repeats
    shape_cfg = {32'd0, mk_shape(1, 0, 1, 0), 32'd0};
    remap_cfg = mk_bind(3, 1, 40, 3, 41, 3);
    op_regs   = {7'd3, 7'd3, 7'd3};
    restart_to(0, 1'b0, "R4");
    do_steps(4, "R4");
    chk(got(0) == 0, "R4", got(0), 0);
    do_steps(5, "R4");

    // R5 zero shape, R6 illegal code, R7 priority and reserved selector
    shape_cfg = {32'd0, mk_shape(2, 2, 0, 6), mk_shape(3, 1, 1, 5)};
    remap_cfg = mk_bind(7, 3, 7, 0, 7, 1);
    op_regs   = {7'd7, 7'd7, 7'd7};
    restart_to(2, 1'b0, "R7");
    do_steps(6, "R7");
    remap_cfg = mk_bind(11, 2, 12, 1, 13, 0);
    op_regs   = {7'd13, 7'd12, 7'd11};
    restart_to(5, 1'b0, "R5");
    chk(got(0) == 5, "R5", got(0), 5);
    chk(got(1) == 5, "R6", got(1), 5);
    chk(perm_err == 1'b1, "R6", int'(perm_err), 1);
    do_steps(4, "R6");

    // R9 R11: restart with step held high across seek
    shape_cfg = {mk_shape(1, 2, 3, 4), mk_shape(4, 1, 2, 1), mk_shape(2, 3, 1, 3)};
    remap_cfg = mk_bind(1, 0, 2, 1, 3, 2);
    op_regs   = {7'd3, 7'd2, 7'd1};
    restart_to(13, 1'b1, "R11");
    restart_to(0, 1'b1, "R11");
    chk(elem_off == '0, "R9", int'(elem_off[20:0]), 0);

    // R10 hold without step
    do_steps(3, "R10");
    for (int i = 0; i < 3; i++) begin
      tick();
      check_now("R10");
    end

    // Random rounds
    for (int r = 0; r < 30; r++) begin
      for (int s = 0; s < 3; s++) begin
        if ($urandom_range(0, 7) == 0) shape_cfg[s*32 +: 32] = 32'd0;
        else shape_cfg[s*32 +: 32] = mk_shape($urandom_range(0, 5), $urandom_range(0, 5),
                                              $urandom_range(0, 5), $urandom_range(0, 7));
      end
      remap_cfg = mk_bind($urandom_range(0, 3), $urandom_range(0, 3),
                          $urandom_range(0, 3), $urandom_range(0, 3),
                          $urandom_range(0, 3), $urandom_range(0, 3));
      op_regs = {7'($urandom_range(0, 3)), 7'($urandom_range(0, 3)), 7'($urandom_range(0, 3))};
      restart_to($urandom_range(0, 40), 1'($urandom_range(0, 1)), "R9");
      do_steps(25, "R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule